// File: doc/BRIEF.md
# Disk Task-File Control Register Block

This block sits on the device side of a parallel disk-interface task file and implements three registers: the 16-bit data port, the device control register and the drive address readback register. A simple synchronous host bus supplies two chip selects (command block and control block), a 3-bit register address, one-cycle read and write strobes and a 16-bit write bus. Read data comes back combinationally in the same cycle as the read strobe, together with a per-bit output enable that marks the bits the device actually drives.

The device control register holds a software-reset request and an active-low interrupt enable. The reset request reaches the device core only after it has been held for a qualifying time. Shorter pulses are filtered out. The interrupt enable gates a registered copy of the core's interrupt request toward the host, together with the device-select input. The drive address readback shows the inverted head number, the inverted drive select and an inverted write-in-progress flag. Its top bit is never driven.

The data port connects the host to the sector buffer through two valid/ready streams. Host reads pop the read stream. Host writes load a one-word holding register that is offered on the write stream until the buffer takes it. The buffer may hold `buf_wr_ready` low for as long as it likes. While the word waits, `buf_wr_valid` and `buf_wr_data` stay unchanged, and any further host write is discarded. On the read side, `buf_rd_ready` is raised only in a cycle where a qualified host read consumes the word offered. Both directions move data only while the core's data-request flag is set. A word counter tracks the position within the block.

Top module: `tfc_ctrl_regs`

## Requirements
- R1: A control-block write at address 6 stores bit 2 as the soft-reset request and bit 1 as the interrupt disable. A read at that address returns, in bits 7..0, bits 7..4 = 0, bit 3 = 1, bit 2 = reset request, bit 1 = interrupt disable and bit 0 = 0, with output enable 0x00FF.
- R2: `core_srst` rises right after the HOLD_CYC-th rising edge that finds the reset request set, where HOLD_CYC = ceil(CLK_HZ x SRST_NS / 1e9). It stays high while the request remains set and falls right after the edge that stores a cleared request.
- R3: A reset request held for fewer edges than that never raises `core_srst` and leaves the interrupt path untouched.
- R4: `host_irq` is registered and equals the previous cycle's `core_irq` AND (interrupt disable = 0) AND `dev_sel` AND NOT `core_srst`.
- R5: A control-block read at address 7 returns bits 1..0 = ~`drive_sel`, bits 5..2 = ~`head` and bit 6 = ~`wr_busy`, with output enable 0x007F, so bit 7 and above stay undriven.
- R6: A command-block read at address 0 with `core_drq`=1 and `buf_rd_valid`=1 returns `buf_rd_data` with output enable 0xFFFF, raises `buf_rd_ready` in that cycle and advances `buf_ptr` by one. With `buf_rd_valid`=0 it returns 0 and pops nothing.
- R7: With `core_drq`=0, data-port reads return 0 without a pop, writes are discarded, and `buf_ptr` does not move.
- R8: A data-port write with `core_drq`=1 and no word pending is offered on the write stream and advances `buf_ptr`. The word is held stable until the handshake `buf_wr_valid`&`buf_wr_ready`.
- R9: A data-port write while a word is still pending is discarded and does not advance `buf_ptr`.
- R10: With `ecc_mode`=1, data reads return only the low byte, with the upper byte 0 and output enable 0x00FF, and written words reach the buffer with the upper byte cleared.
- R11: While `core_srst` is high, `core_drq` is treated as 0, `buf_ptr` goes to 0, any pending write word is dropped and `host_irq` goes to 0. The interrupt disable keeps its value.
- R12: Hardware reset clears the reset request and the interrupt disable, which leaves interrupts enabled. It also clears `host_irq`, `buf_ptr` and `buf_wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_cmd | input | 1 | Command-block chip select |
| cs_ctl | input | 1 | Control-block chip select |
| haddr | input | 3 | Register address |
| hrd | input | 1 | Read strobe, one cycle per access |
| hwr | input | 1 | Write strobe, one cycle per access |
| hwdata | input | DATA_W | Host write data |
| hrdata | output | DATA_W | Host read data, same cycle as hrd |
| hrdata_oe | output | DATA_W | Per-bit output enable for hrdata |
| core_irq | input | 1 | Interrupt request from the device core |
| dev_sel | input | 1 | This device is the selected one |
| host_irq | output | 1 | Gated, registered interrupt toward the host |
| core_srst | output | 1 | Qualified soft reset toward the device core |
| core_drq | input | 1 | Data-request flag from the core |
| ecc_mode | input | 1 | Current transfer is ECC bytes |
| head | input | 4 | Current head number |
| drive_sel | input | 2 | Current drive select |
| wr_busy | input | 1 | Media write in progress |
| buf_rd_valid | input | 1 | Buffer offers a read word |
| buf_rd_ready | output | 1 | Host consumes the offered word |
| buf_rd_data | input | DATA_W | Offered read word |
| buf_wr_valid | output | 1 | Write word pending for the buffer |
| buf_wr_ready | input | 1 | Buffer accepts the pending word |
| buf_wr_data | output | DATA_W | Pending write word |
| buf_ptr | output | PTR_W | Word position within the block |

## Verification
The collision of interest is the qualification of soft reset landing on the same clock edge as a data-port read. The bench counts edges from the write that sets the reset request and places a host read in the cycle that ends with the HOLD_CYC-th edge. The read must still return the buffer word and advance `buf_ptr` on that edge, while `core_srst` rises. On the following edge the pointer must clear, `host_irq` must fall and the pending write word must vanish without a handshake. A second collision, an interrupt request meeting a control write that changes the enable, is judged by sampling `host_irq` one and two cycles after the write.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  // Register addresses inside each block.
  localparam logic [2:0] DATA_ADDR   = 3'd0;
  localparam logic [2:0] DEVCTL_ADDR = 3'd6;
  localparam logic [2:0] DRVADR_ADDR = 3'd7;

  // Device control bit positions (decoded by host software).
  localparam int unsigned SRST_BIT = 2;
  localparam int unsigned NIEN_BIT = 1;

  localparam int unsigned HEAD_W = 4;
  localparam int unsigned DSEL_W = 2;

  typedef struct packed {
    logic srst;   // soft-reset request
    logic nien;   // interrupt disable (active-low enable)
  } devctl_t;
endpackage

// File: rtl/tfc_srst_qual.sv
module tfc_srst_qual #(
  parameter int unsigned HOLD_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_bit_i,
  output logic core_srst_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!srst_bit_i)      cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign core_srst_o = srst_bit_i && (cnt_q == CNT_MAX);

  // R2
  srst_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_srst_o && srst_bit_i) |=> (core_srst_o || !srst_bit_i));

  // R3
  srst_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_srst_o) |-> $past(srst_bit_i));
endmodule

// File: rtl/tfc_devctl.sv
module tfc_devctl
  import tfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       soft_rst,
  input  logic       core_irq,
  input  logic       dev_sel,
  output devctl_t    regs_o,
  output logic       host_irq_o
);
  devctl_t regs_q;
  logic    irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      regs_q.srst <= wdata[SRST_BIT];
      regs_q.nien <= wdata[NIEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= core_irq && !regs_q.nien && dev_sel && !soft_rst;
  end

  assign regs_o     = regs_q;
  assign host_irq_o = irq_q;

  // R4
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_o |-> $past(dev_sel && core_irq));

  // R11
  irq_quiet_in_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !host_irq_o);
endmodule

// File: rtl/tfc_dataport.sv
module tfc_dataport #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PTR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              drq_i,
  input  logic              ecc_i,
  input  logic              rd_sel,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] rd_word_o,
  input  logic              buf_rd_valid,
  output logic              buf_rd_ready,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              buf_wr_valid,
  input  logic              buf_wr_ready,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic [PTR_W-1:0]  ptr_o
);
  localparam int unsigned HI_W = DATA_W - 8;

  logic              drq_eff, rd_go, wr_go;
  logic              pend_q;
  logic [DATA_W-1:0] wdat_q;
  logic [PTR_W-1:0]  ptr_q;

  assign drq_eff = drq_i && !soft_rst;
  assign rd_go   = rd_sel && drq_eff && buf_rd_valid;
  assign wr_go   = wr_sel && drq_eff && !pend_q;

  always_comb begin
    rd_word_o = '0;
    if (rd_go) rd_word_o = ecc_i ? {{HI_W{1'b0}}, buf_rd_data[7:0]} : buf_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wdat_q <= '0;
    end else if (soft_rst) begin
      pend_q <= 1'b0;
    end else if (wr_go) begin
      pend_q <= 1'b1;
      wdat_q <= ecc_i ? {{HI_W{1'b0}}, hwdata[7:0]} : hwdata;
    end else if (pend_q && buf_wr_ready) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ptr_q <= '0;
    else if (soft_rst)       ptr_q <= '0;
    else if (rd_go || wr_go) ptr_q <= ptr_q + 1'b1;
  end

  assign buf_rd_ready = rd_go;
  assign buf_wr_valid = pend_q;
  assign buf_wr_data  = wdat_q;
  assign ptr_o        = ptr_q;

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_valid && !buf_wr_ready && !soft_rst) |=> (buf_wr_valid && $stable(buf_wr_data)));

  // R7
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drq_i && !soft_rst) |=> $stable(ptr_o));

  // R11
  srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ptr_o == '0 && !buf_wr_valid));
endmodule

// File: rtl/tfc_ctrl_regs.sv
module tfc_ctrl_regs
  import tfc_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BLK_WORDS = 256,
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned SRST_NS   = 5000,
  localparam int unsigned PTR_W    = $clog2(BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_cmd,
  input  logic              cs_ctl,
  input  logic [2:0]        haddr,
  input  logic              hrd,
  input  logic              hwr,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic [DATA_W-1:0] hrdata_oe,
  input  logic              core_irq,
  input  logic              dev_sel,
  output logic              host_irq,
  output logic              core_srst,
  input  logic              core_drq,
  input  logic              ecc_mode,
  input  logic [3:0]        head,
  input  logic [1:0]        drive_sel,
  input  logic              wr_busy,
  input  logic              buf_rd_valid,
  output logic              buf_rd_ready,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              buf_wr_valid,
  input  logic              buf_wr_ready,
  output logic [DATA_W-1:0] buf_wr_data,
  output logic [PTR_W-1:0]  buf_ptr
);
  localparam longint unsigned HOLD_L =
    ((longint'(CLK_HZ) / 1_000_000) * longint'(SRST_NS) + 999) / 1000;
  localparam int unsigned HOLD_CYC = (HOLD_L == 0) ? 1 : int'(HOLD_L);

  logic              data_hit, dc_wr, dc_rd, da_rd;
  logic [DATA_W-1:0] port_word;
  devctl_t           dc;

  assign data_hit = cs_cmd && (haddr == DATA_ADDR);
  assign dc_wr    = cs_ctl && !cs_cmd && hwr && (haddr == DEVCTL_ADDR);
  assign dc_rd    = cs_ctl && !cs_cmd && hrd && (haddr == DEVCTL_ADDR);
  assign da_rd    = cs_ctl && !cs_cmd && hrd && (haddr == DRVADR_ADDR);

  tfc_devctl u_devctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (dc_wr),
    .wdata      (hwdata[7:0]),
    .soft_rst   (core_srst),
    .core_irq   (core_irq),
    .dev_sel    (dev_sel),
    .regs_o     (dc),
    .host_irq_o (host_irq)
  );

  tfc_srst_qual #(.HOLD_CYC(HOLD_CYC)) u_srst (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst_bit_i  (dc.srst),
    .core_srst_o (core_srst)
  );

  tfc_dataport #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_data (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (core_srst),
    .drq_i        (core_drq),
    .ecc_i        (ecc_mode),
    .rd_sel       (data_hit && hrd),
    .wr_sel       (data_hit && hwr),
    .hwdata       (hwdata),
    .rd_word_o    (port_word),
    .buf_rd_valid (buf_rd_valid),
    .buf_rd_ready (buf_rd_ready),
    .buf_rd_data  (buf_rd_data),
    .buf_wr_valid (buf_wr_valid),
    .buf_wr_ready (buf_wr_ready),
    .buf_wr_data  (buf_wr_data),
    .ptr_o        (buf_ptr)
  );

  always_comb begin
    hrdata    = '0;
    hrdata_oe = '0;
    if (data_hit && hrd) begin
      hrdata    = port_word;
      hrdata_oe = ecc_mode ? DATA_W'(8'hFF) : '1;
    end else if (dc_rd) begin
      hrdata    = DATA_W'({4'b0000, 1'b1, dc.srst, dc.nien, 1'b0});
      hrdata_oe = DATA_W'(8'hFF);
    end else if (da_rd) begin
      hrdata    = DATA_W'({1'b0, ~wr_busy, ~head, ~drive_sel});
      hrdata_oe = DATA_W'(8'h7F);
    end
  end

  // R5
  drvadr_top_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    da_rd |-> !hrdata_oe[7]);
endmodule

// File: tb/test_tfc_ctrl_regs.sv
`timescale 1ns/1ps
module test_tfc_ctrl_regs;
  localparam int DATA_W = 16;
  localparam int PTR_W  = 8;
  localparam int HOLD   = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_cmd = 0, cs_ctl = 0, hrd = 0, hwr = 0;
  logic [2:0] haddr = '0;
  logic [15:0] hwdata = '0, hrdata, hrdata_oe;
  logic core_irq = 0, dev_sel = 0, host_irq, core_srst;
  logic core_drq = 0, ecc_mode = 0, wr_busy = 0;
  logic [3:0] head = '0;
  logic [1:0] drive_sel = '0;
  logic buf_rd_valid = 0, buf_rd_ready, buf_wr_valid, buf_wr_ready = 0;
  logic [15:0] buf_rd_data, buf_wr_data;
  logic [PTR_W-1:0] buf_ptr;

  tfc_ctrl_regs i_tfc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .haddr(haddr),
    .hrd(hrd), .hwr(hwr), .hwdata(hwdata), .hrdata(hrdata), .hrdata_oe(hrdata_oe),
    .core_irq(core_irq), .dev_sel(dev_sel), .host_irq(host_irq), .core_srst(core_srst),
    .core_drq(core_drq), .ecc_mode(ecc_mode), .head(head), .drive_sel(drive_sel),
    .wr_busy(wr_busy), .buf_rd_valid(buf_rd_valid), .buf_rd_ready(buf_rd_ready),
    .buf_rd_data(buf_rd_data), .buf_wr_valid(buf_wr_valid), .buf_wr_ready(buf_wr_ready),
    .buf_wr_data(buf_wr_data), .buf_ptr(buf_ptr)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  logic [7:0] rd_idx = '0;

  function automatic logic [15:0] pat(int i);
    return 16'hC300 ^ (16'(i) * 16'h0111);
  endfunction

  assign buf_rd_data = pat(int'(rd_idx));
  always @(posedge clk) if (buf_rd_valid && buf_rd_ready) rd_idx <= rd_idx + 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: write-stream handshakes against queued expectations.
  always @(negedge clk) begin
    #2;
    if (rst_n && buf_wr_valid === 1'b1 && buf_wr_ready) begin
      if (exp_q.size() == 0) chk("R8 unexpected word", {16'h0, buf_wr_data}, 32'hFFFF_FFFF);
      else chk("R8 stream word", {16'h0, buf_wr_data}, {16'h0, exp_q.pop_front()});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(logic [2:0] a, logic [7:0] d);
    cs_ctl = 1; haddr = a; hwdata = {8'h00, d}; hwr = 1;
    @(negedge clk);
    cs_ctl = 0; hwr = 0;
  endtask

  task automatic host_read(bit cmd, logic [2:0] a, output logic [15:0] d, output logic [15:0] oe);
    cs_cmd = cmd; cs_ctl = !cmd; haddr = a; hrd = 1;
    #1 d = hrdata; oe = hrdata_oe;
    @(negedge clk);
    cs_cmd = 0; cs_ctl = 0; hrd = 0;
  endtask

  // Driver: pushes the word the buffer must see when the write is expected to land.
  task automatic data_write(logic [15:0] v, bit accept);
    if (accept) exp_q.push_back(ecc_mode ? {8'h00, v[7:0]} : v);
    cs_cmd = 1; haddr = 3'd0; hwdata = v; hwr = 1;
    @(negedge clk);
    cs_cmd = 0; hwr = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, oe;
    bit seen;
    idle(3); rst_n = 1; idle(1);

    // R12 reset state
    chk("R12 core_srst", core_srst, 0);
    chk("R12 host_irq", host_irq, 0);
    chk("R12 buf_ptr", buf_ptr, 0);
    chk("R12 buf_wr_valid", buf_wr_valid, 0);
    host_read(0, 3'd6, d, oe);
    chk("R12 devctl after reset", d, 16'h0008);
    chk("R1 devctl oe", oe, 16'h00FF);

    // R1 write / readback layout
    ctl_write(3'd6, 8'hFA);
    host_read(0, 3'd6, d, oe);
    chk("R1 devctl readback", d, 16'h000A);

    // R5 drive address readback
    head = 4'h5; drive_sel = 2'b10; wr_busy = 1;
    host_read(0, 3'd7, d, oe);
    chk("R5 drvadr busy", d, 16'h0029);
    chk("R5 drvadr oe", oe, 16'h007F);
    wr_busy = 0;
    host_read(0, 3'd7, d, oe);
    chk("R5 drvadr idle", d, 16'h0069);

    // R4 interrupt gating and one-cycle latency
    core_irq = 1; dev_sel = 1; idle(2);
    chk("R4 disabled", host_irq, 0);
    ctl_write(3'd6, 8'h00);
    chk("R4 latency after enable", host_irq, 0);
    idle(1);
    chk("R4 enabled", host_irq, 1);
    dev_sel = 0; #1;
    chk("R4 before edge", host_irq, 1);
    @(negedge clk);
    chk("R4 deselected", host_irq, 0);
    dev_sel = 1; idle(1);
    chk("R4 reselected", host_irq, 1);

    // R7 no DRQ
    buf_rd_valid = 1;
    host_read(1, 3'd0, d, oe);
    chk("R7 read without drq", d, 16'h0000);
    data_write(16'h7777, 0);
    idle(3);
    chk("R7 ptr still", buf_ptr, 0);

    // R6 reads with DRQ
    core_drq = 1;
    for (int i = 0; i < 3; i++) begin
      host_read(1, 3'd0, d, oe);
      chk("R6 read word", d, pat(i));
      chk("R6 read oe", oe, 16'hFFFF);
    end
    chk("R6 ptr", buf_ptr, 3);
    buf_rd_valid = 0;
    host_read(1, 3'd0, d, oe);
    chk("R6 empty buffer", d, 16'h0000);
    chk("R6 ptr no pop", buf_ptr, 3);
    buf_rd_valid = 1;

    // R8 write stream
    buf_wr_ready = 1;
    data_write(16'h1234, 1);
    idle(2);
    chk("R8 ptr", buf_ptr, 4);
    chk("R8 drained", exp_q.size(), 0);

    // R9 overrun while pending
    buf_wr_ready = 0;
    data_write(16'hBEEF, 1);
    data_write(16'hDEAD, 0);
    chk("R9 ptr", buf_ptr, 5);
    chk("R9 pending word", buf_wr_data, 16'hBEEF);
    buf_wr_ready = 1; idle(2);
    chk("R9 drained", exp_q.size(), 0);

    // R10 ECC byte mode
    ecc_mode = 1;
    host_read(1, 3'd0, d, oe);
    chk("R10 ecc read", d, {8'h00, pat(3)[7:0]});
    chk("R10 ecc oe", oe, 16'h00FF);
    data_write(16'hABCD, 1);
    idle(2);
    chk("R10 ptr", buf_ptr, 7);
    chk("R10 drained", exp_q.size(), 0);
    ecc_mode = 0;

    // R3 short reset pulse
    seen = 0;
    ctl_write(3'd6, 8'h04);
    for (int i = 0; i < HOLD - 2; i++) begin
      seen |= core_srst;
      @(negedge clk);
    end
    seen |= core_srst;
    ctl_write(3'd6, 8'h00);
    idle(3);
    chk("R3 no reset seen", {31'h0, seen}, 0);
    chk("R3 irq untouched", host_irq, 1);

    // R2 / R11 qualified reset colliding with a data read
    buf_wr_ready = 0;
    data_write(16'h5555, 0);
    chk("R11 setup ptr", buf_ptr, 8);
    ctl_write(3'd6, 8'h04);
    idle(HOLD - 1);
    chk("R2 not yet", core_srst, 0);
    host_read(1, 3'd0, d, oe);
    chk("R11 read at qualifying edge", d, pat(4));
    chk("R2 asserted", core_srst, 1);
    chk("R11 ptr advanced on edge", buf_ptr, 9);
    chk("R4 irq still registered", host_irq, 1);
    idle(1);
    chk("R11 ptr cleared", buf_ptr, 0);
    chk("R11 irq cleared", host_irq, 0);
    chk("R11 pending dropped", buf_wr_valid, 0);
    host_read(1, 3'd0, d, oe);
    chk("R11 drq ignored", d, 16'h0000);
    host_read(0, 3'd6, d, oe);
    chk("R1 devctl in reset", d, 16'h000C);
    ctl_write(3'd6, 8'h06);
    host_read(0, 3'd6, d, oe);
    chk("R11 nien set in reset", d, 16'h000E);
    idle(5);
    chk("R2 held", core_srst, 1);
    ctl_write(3'd6, 8'h02);
    chk("R2 released", core_srst, 0);
    host_read(0, 3'd6, d, oe);
    chk("R11 nien survived", d, 16'h000A);
    chk("R4 disabled after reset", host_irq, 0);
    buf_wr_ready = 1; idle(2);
    chk("R11 no stale word", exp_q.size(), 0);
    host_read(1, 3'd0, d, oe);
    chk("R6 read after reset", d, pat(5));
    chk("R6 ptr after reset", buf_ptr, 1);

    // R12 hardware reset mid-run
    rst_n = 0; #1;
    chk("R12 irq in reset", host_irq, 0);
    chk("R12 ptr in reset", buf_ptr, 0);
    idle(2); rst_n = 1; idle(1);
    host_read(0, 3'd6, d, oe);
    chk("R12 devctl cleared", d, 16'h0008);
    chk("R12 irq enabled again", host_irq, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule